// File: doc/BRIEF.md
# Parallel-Jam Serial Shift Register

This block is a chain of storage stages that either shifts a serial bit stream in on the rising clock edge or takes a whole parallel word at once. A single mode control input picks between the two. When the control is low, every rising edge moves the contents one stage toward the last stage and the serial input bit enters the first stage. When the control is high, the parallel word is written into the stages. The last three stages are brought out as taps, so a reader can see the final bit and the two bits before it.

A build-time parameter picks how the parallel word is written. In the clocked variant the word is captured only on a rising edge. In the jam variant each stage is forced by its own asynchronous set or clear. The stages follow the parallel inputs for as long as the control stays high, and the clock has no effect during that time. The last value jammed in is held after the control falls, and the next rising edge shifts it. To build a longer register, feed the last tap of one instance into the serial input of the next instance.

Top module: `jam_shift_register`

## Requirements
- R1: While reset is asserted, and on the first clock edges after it is released, every stage holds 0, so all three taps read 0.
- R2: With the mode control low, each rising clock edge moves stage k into stage k+1, and serial input bit `ser_i` enters stage 1.
- R3: In the clocked-load variant, a rising edge with the mode control high writes `par_i[k]` into stage k+1.
- R4: In the clocked-load variant, raising the mode control and changing `par_i` between edges leaves the taps unchanged until the next rising edge.
- R5: In the jam variant, while the mode control is high the stages follow `par_i` without a clock edge, and rising clock edges do not shift.
- R6: In the jam variant, the value held when the mode control falls stays in place until the next rising edge, even if `par_i` changes. That edge shifts the held value.
- R7: `tap_o[0]`, `tap_o[1]` and `tap_o[2]` carry stages 6, 7 and 8 of the default 8-stage register.
- R8: When `tap_o[2]` of one instance drives `ser_i` of a second instance, and both share clock, mode control and parallel word, the pair acts as one 16-stage register.
- R9: In the jam variant, reset clears every stage even while the mode control is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Mode control: 1 = parallel load, 0 = serial shift |
| ser_i | input | 1 | Serial data entering stage 1 |
| par_i | input | NUM_STAGES | Parallel word, bit k for stage k+1 |
| tap_o | output | NUM_TAPS | Last stages; the top bit is the final stage |

## Verification
The hardest case to reach is in the jam variant: the mode control falls a moment before a rising edge while the parallel word changes at the same moment. The stages must keep the jammed value across that gap, and the edge must then shift the kept value. The bench drops the control and swaps the word two time units before the edge. It reads the taps one unit before the edge and again one unit after it. Constrained random sequences with a fixed seed add mid-cycle jam loads and shifts on both variants and on a cascaded pair, and each is compared against queue models kept in the bench.

// File: rtl/jam_shift_pkg.sv
package jam_shift_pkg;

  typedef enum logic {
    LOAD_CLOCKED = 1'b0,
    LOAD_JAM     = 1'b1
  } load_kind_e;

endpackage

// File: rtl/jam_rst_sync.sv
module jam_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[DEPTH-1];

endmodule

// File: rtl/jam_stage_clocked.sv
module jam_stage_clocked (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic par_bit_i,
  input  logic shift_bit_i,
  output logic q_o
);

  logic q_d;
  logic q_q;

  always_comb begin
    if (load_i) begin
      q_d = par_bit_i;
    end else begin
      q_d = shift_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/jam_stage_async.sv
module jam_stage_async (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic par_bit_i,
  input  logic shift_bit_i,
  output logic q_o
);

  logic jam_set;
  logic jam_clr;
  logic q_q;

  always_comb begin
    jam_set = load_i & par_bit_i;
    jam_clr = load_i & ~par_bit_i;
  end

  // Reset first, then the jam clear/set, then the clocked shift.
  always_ff @(posedge clk or negedge rst_n or posedge jam_set or posedge jam_clr) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (jam_clr) begin
      q_q <= 1'b0;
    end else if (jam_set) begin
      q_q <= 1'b1;
    end else begin
      q_q <= shift_bit_i;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/jam_shift_register.sv
module jam_shift_register
  import jam_shift_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8,
  parameter int unsigned NUM_TAPS   = 3,
  parameter load_kind_e  LOAD_KIND  = LOAD_CLOCKED
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  ser_i,
  input  logic [NUM_STAGES-1:0] par_i,
  output logic [NUM_TAPS-1:0]   tap_o
);

  localparam int unsigned TAP_LSB = NUM_STAGES - NUM_TAPS;
  localparam bit          IS_JAM  = (LOAD_KIND == LOAD_JAM);

  logic                  rst_int_n;
  logic [NUM_STAGES-1:0] stage_q;
  logic [NUM_STAGES-1:0] shift_in;

  jam_rst_sync #(
    .DEPTH (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Serial path: stage 1 takes the serial input, each other stage its neighbour.
  always_comb begin
    shift_in = {stage_q[NUM_STAGES-2:0], ser_i};
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (IS_JAM) begin : g_jam
      jam_stage_async u_cell (
        .clk         (clk),
        .rst_n       (rst_int_n),
        .load_i      (load_i),
        .par_bit_i   (par_i[g]),
        .shift_bit_i (shift_in[g]),
        .q_o         (stage_q[g])
      );
    end else begin : g_clk
      jam_stage_clocked u_cell (
        .clk         (clk),
        .rst_n       (rst_int_n),
        .load_i      (load_i),
        .par_bit_i   (par_i[g]),
        .shift_bit_i (shift_in[g]),
        .q_o         (stage_q[g])
      );
    end
  end

  assign tap_o = stage_q[NUM_STAGES-1:TAP_LSB];

  // R2: a serial edge moves every bit one stage up
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load_i |=> (IS_JAM && load_i) ||
                (stage_q == {$past(stage_q[NUM_STAGES-2:0]), $past(ser_i)}));

  // R7: consecutive taps pass bits along on a shift
  assert_tap_chain_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load_i |=> (IS_JAM && load_i) ||
                (tap_o[NUM_TAPS-1:1] == $past(tap_o[NUM_TAPS-2:0])));

  if (IS_JAM) begin : g_jam_checks
    // R5: while jamming, the stages mirror the parallel word at every edge
    assert_jam_follow_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
      (load_i && $past(load_i)) |-> stage_q == par_i);
  end else begin : g_clk_checks
    // R3: a load edge captures the parallel word
    assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
      load_i |=> stage_q == $past(par_i));
  end

endmodule

// File: tb/jam_shift_register_bench.sv
`timescale 1ns/100ps
module jam_shift_register_bench;
  import jam_shift_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       load;
  logic       ser;
  logic       casc_ser;
  logic [7:0] par;
  logic [2:0] tap_clk;
  logic [2:0] tap_jam;
  logic [2:0] tap_ca;
  logic [2:0] tap_cb;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_clk;
  logic [7:0]  m_jam;
  logic [15:0] m_casc;

  jam_shift_register #(.LOAD_KIND(LOAD_CLOCKED)) u_jam_shift_register (
    .clk(clk), .rst_n(rst_n), .load_i(load), .ser_i(ser), .par_i(par), .tap_o(tap_clk));

  jam_shift_register #(.LOAD_KIND(LOAD_JAM)) u_jam_variant (
    .clk(clk), .rst_n(rst_n), .load_i(load), .ser_i(ser), .par_i(par), .tap_o(tap_jam));

  jam_shift_register #(.LOAD_KIND(LOAD_CLOCKED)) u_casc_a (
    .clk(clk), .rst_n(rst_n), .load_i(load), .ser_i(casc_ser), .par_i(par), .tap_o(tap_ca));

  jam_shift_register #(.LOAD_KIND(LOAD_CLOCKED)) u_casc_b (
    .clk(clk), .rst_n(rst_n), .load_i(load), .ser_i(tap_ca[2]), .par_i(par), .tap_o(tap_cb));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: taps actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Model update for one rising edge with the given sampled inputs
  task automatic edge_model(input logic ld, input logic s, input logic [7:0] p, input logic cs);
    if (ld) begin
      m_clk  = p;
      m_casc = {p, p};
    end else begin
      m_clk  = {m_clk[6:0], s};
      m_casc = {m_casc[14:0], cs};
      m_jam  = {m_jam[6:0], s};
    end
  endtask

  task automatic check_all(input string tag);
    chk({"R2/R3/R7 clocked ", tag}, tap_clk, m_clk[7:5]);
    chk({"R2/R5/R7 jam ", tag}, tap_jam, m_jam[7:5]);
    chk({"R8 cascade ", tag}, tap_cb, m_casc[15:13]);
  endtask

  task automatic step(input logic ld, input logic s, input logic [7:0] p, input logic cs);
    @(negedge clk);
    load = ld; ser = s; par = p; casc_ser = cs;
    #1;
    if (ld) begin
      m_jam = p;
      chk("R5 jam follows without edge", tap_jam, p[7:5]);
      chk("R4 clocked waits for edge", tap_clk, m_clk[7:5]);
    end
    @(posedge clk);
    edge_model(ld, s, p, cs);
    #1;
    check_all("after edge");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load = 1'b0;
    #1;
    m_clk = '0; m_jam = '0; m_casc = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset clocked", tap_clk, 3'b000);
    chk("R1 reset jam", tap_jam, 3'b000);
    chk("R1 reset cascade", tap_cb, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    rst_n = 1'b0; load = 1'b0; ser = 1'b0; casc_ser = 1'b0; par = '0;
    seed_dummy = $urandom(32'd4021);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_clk = '0; m_jam = '0; m_casc = '0;
    chk("R1 reset clocked", tap_clk, 3'b000);
    chk("R1 reset jam", tap_jam, 3'b000);

    // R2/R7: walk a single one through the stage taps
    step(1'b0, 1'b1, 8'h00, 1'b1);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 8'h00, 1'b0);

    // R3/R5: parallel loads of distinct words
    step(1'b1, 1'b0, 8'hA5, 1'b0);
    step(1'b0, 1'b1, 8'h00, 1'b0);
    step(1'b1, 1'b1, 8'h5A, 1'b1);
    step(1'b1, 1'b0, 8'hE0, 1'b1);

    // R5: clock ignored while jamming, word changed mid-cycle
    @(negedge clk);
    load = 1'b1; par = 8'hC3; ser = 1'b1; casc_ser = 1'b0;
    #1 chk("R5 jam follows word", tap_jam, 3'b110);
    #1 par = 8'h20;
    #1 chk("R5 jam follows change", tap_jam, 3'b001);
    chk("R4 clocked unchanged mid-cycle", tap_clk, m_clk[7:5]);
    @(posedge clk);
    edge_model(1'b1, 1'b1, 8'h20, 1'b0);
    m_jam = 8'h20;
    #1 check_all("R5 edge with load high");
    @(posedge clk);
    edge_model(1'b1, 1'b1, 8'h20, 1'b0);
    #1 chk("R5 clock ignored while jamming", tap_jam, 3'b001);

    // R6: control drops just before the edge while the word changes
    @(negedge clk);
    par = 8'hC0;
    m_jam = 8'hC0;
    @(posedge clk);
    edge_model(1'b1, 1'b1, 8'hC0, 1'b0);
    #(CLK_PERIOD - 2);
    load = 1'b0; par = 8'h3F; ser = 1'b0; casc_ser = 1'b1;
    #1 chk("R6 value held after control falls", tap_jam, 3'b110);
    @(posedge clk);
    edge_model(1'b0, 1'b0, 8'h3F, 1'b1);
    #1 chk("R6 first shift uses jammed value", tap_jam, 3'b100);
    check_all("R6 after drop");

    // R9: reset wins over an active jam
    @(negedge clk);
    load = 1'b1; par = 8'hFF;
    #1 chk("R9 jam before reset", tap_jam, 3'b111);
    rst_n = 1'b0;
    #1 chk("R9 reset clears during jam", tap_jam, 3'b000);
    load = 1'b0;
    do_reset();

    // Random mix on all instances
    for (int n = 0; n < 400; n++) begin
      logic       ld;
      logic       s;
      logic       cs;
      logic [7:0] p;
      ld = ($urandom % 4) == 0;
      s  = $urandom % 2;
      cs = $urandom % 2;
      p  = 8'($urandom);
      step(ld, s, p, cs);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule